// File: doc/BRIEF.md
# Two-Stage Segmented Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address. Pages are 512 bytes. The top two bits of the virtual address pick a region. There are two per-process regions (code/data and stack), one system region and one forbidden region. A system address needs one page-table entry, fetched from physical memory at the system table base. A per-process address is different: its entry lives in system virtual space. The block therefore first forms the entry's system virtual address from the matching process base. It then translates that address through the system table, and only then reads the user entry. Each entry is a 32-bit word:

| Entry bits | Meaning |
|---|---|
| 31 | present (valid) |
| 30 | write permit |
| 29:27 | rest of the protection field; not checked |
| 26 | modified; not checked |
| 25:21 | ignored |
| 20:0 | physical frame number |

The block takes one request at a time. Requests, page-table reads and results each use a valid/ready handshake, and back-pressure is honoured on all three:
- **Requests** are accepted only while the block is idle with nothing pending.
- **Page-table reads**: a read request holds its address until the memory raises ready. The reply is a one-cycle valid pulse with no back-pressure. Replies are only looked at while a read is outstanding.
- **Results**: the result (physical address plus 2-bit status) is held until the consumer accepts it.

The base registers are plain inputs. They are sampled together with the request.

Top module: `seg_xlate`

## Requirements
- R1: A virtual address whose bits 31:30 are 11 completes with status 3 (protection/region fault). The result is valid two cycles after acceptance, and no page-table read is issued.
- R2: A system address (bits 31:30 = 10) issues exactly one read, at (system base + VPN×4) modulo 2^30, where VPN is vaddr bits 29:9. If that entry is present and the access is allowed, the block returns status 0 with physical address {entry[20:0], vaddr[8:0]}.
- R3: For a process address, the entry's virtual address is (process base + VPN×4) modulo 2^32. Bits 31:30 = 00 use the code/data base and 01 use the stack base. If that entry address does not have bits 31:30 = 10, the block returns status 3 two cycles after acceptance, with no read.
- R4: A process address issues two reads. The first is at system base + (entry VA bits 29:9)×4. The second is at {first entry[20:0], entry VA[8:0]}. Success returns status 0 with address {second entry[20:0], vaddr[8:0]}.
- R5: If the system-stage entry has bit 31 clear, the status is 1 (system page fault) and no further read is issued. This holds for system addresses and for the first stage of process addresses.
- R6: If the second (user) entry of a process access has bit 31 clear, the status is 2 (user page fault).
- R7: A write whose final entry is present but has bit 30 clear returns status 3. A read of the same entry succeeds. A page fault takes priority over this check. Every non-zero status carries physical address 0.
- R8: req_ready is high only when idle, with no read outstanding and no result pending. After reset, req_ready is 1 and rd_req_valid and resp_valid are 0.
- R9: While resp_valid is high and resp_ready is low, resp_valid, resp_paddr and resp_status hold their values.
- R10: While rd_req_valid is high and rd_req_ready is low, rd_req_valid and rd_addr hold their values.
- R11: The address, access kind and all three bases are captured at acceptance. Later changes on these inputs do not affect the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| sys_base | input | 30 | Physical base of the system page table |
| proc0_base | input | 32 | System-virtual base of the code/data page table |
| proc1_base | input | 32 | System-virtual base of the stack page table |
| rd_req_valid | output | 1 | Page-table read request |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 30 | Physical address of the entry to read |
| rd_rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| rd_rsp_data | input | 32 | Page-table entry word |
| resp_valid | output | 1 | Result valid |
| resp_ready | input | 1 | Consumer accepts the result |
| resp_paddr | output | 30 | Physical address (0 on any fault) |
| resp_status | output | 2 | 0 ok, 1 system page fault, 2 user page fault, 3 protection/region fault |

## Verification
**Faults decided without memory.** A forbidden region or an entry address outside system space produces a result two cycles after acceptance. The bench counts negative edges from the acceptance edge and demands resp_valid on exactly the second.

**Results that need memory.** Their timing depends on the random delays of the memory model: read grant, then reply one to three cycles later. The bench waits for resp_valid at negative edges and then checks the result. It also checks the number and order of read addresses logged by the memory model.

**Holding under back-pressure.** The consumer stalls the result for up to two cycles and the memory model delays its grant. The bench samples on every stalled negative edge, so any value that changes while it should hold is caught in the cycle it changes.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Width of one page-table entry word
  localparam int PTE_W = 32;

  // Entry bit positions the block decodes
  localparam int PTE_VALID_BIT = 31;
  localparam int PTE_WR_BIT    = 30;

  // Region codes carried in the top two virtual address bits
  localparam logic [1:0] REG_P0  = 2'b00;
  localparam logic [1:0] REG_P1  = 2'b01;
  localparam logic [1:0] REG_SYS = 2'b10;
  localparam logic [1:0] REG_BAD = 2'b11;

  // Completion codes
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_SYS_PF = 2'd1,
    ST_USR_PF = 2'd2,
    ST_PROT   = 2'd3
  } xl_status_e;

endpackage

// File: rtl/seg_xlate_addr.sv
// Address arithmetic: region decode, entry pointers for both stages.
module seg_xlate_addr
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 9
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PA_W-1:0]  sys_base,
  input  logic [VA_W-1:0]  p0_base,
  input  logic [VA_W-1:0]  p1_base,
  output logic [1:0]       region,
  output logic             ent_bad,
  output logic [OFF_W-1:0] ent_off,
  output logic [PA_W-1:0]  sys_pa_direct,
  output logic [PA_W-1:0]  sys_pa_nested
);
  localparam int VPN_W = VA_W - 2 - OFF_W;

  logic [VPN_W-1:0] vpn;
  logic [VPN_W-1:0] ent_vpn;
  logic [VA_W-1:0]  user_base;
  logic [VA_W-1:0]  ent_va;

  assign region  = vaddr[VA_W-1 -: 2];
  assign vpn     = vaddr[VA_W-3:OFF_W];

  // Stack region has bit 30 set
  assign user_base = region[0] ? p1_base : p0_base;

  // Entry address of a process page, in system virtual space
  assign ent_va  = user_base + VA_W'({vpn, 2'b00});
  assign ent_vpn = ent_va[VA_W-3:OFF_W];
  assign ent_off = ent_va[OFF_W-1:0];
  assign ent_bad = (ent_va[VA_W-1 -: 2] != REG_SYS);

  // System-table entry addresses for the direct and nested cases
  assign sys_pa_direct = sys_base + PA_W'({vpn, 2'b00});
  assign sys_pa_nested = sys_base + PA_W'({ent_vpn, 2'b00});

endmodule

// File: rtl/seg_xlate_pte.sv
// Entry decode: presence, write permission, frame/offset merge.
module seg_xlate_pte
  import seg_xlate_pkg::*;
#(
  parameter int PA_W  = 30,
  parameter int OFF_W = 9
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  input  logic [OFF_W-1:0] offset,
  output logic             present,
  output logic             perm_fault,
  output logic [PA_W-1:0]  phys
);
  localparam int PFN_W = PA_W - OFF_W;

  assign present    = pte[PTE_VALID_BIT];
  assign perm_fault = is_write & ~pte[PTE_WR_BIT];
  assign phys       = {pte[PFN_W-1:0], offset};

  // Remaining protection, modified and spare bits do not affect the result
  logic unused_pte_bits;
  assign unused_pte_bits = ^pte[PTE_WR_BIT-1:PFN_W];

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic [PA_W-1:0]  sys_base,
  input  logic [VA_W-1:0]  proc0_base,
  input  logic [VA_W-1:0]  proc1_base,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [PA_W-1:0]  rd_addr,
  input  logic             rd_rsp_valid,
  input  logic [PTE_W-1:0] rd_rsp_data,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [1:0]       resp_status
);

  typedef enum logic [2:0] {
    S_IDLE, S_CLASS, S_SYS_REQ, S_SYS_WAIT, S_USR_REQ, S_USR_WAIT, S_DONE
  } state_e;

  state_e           state;
  logic [VA_W-1:0]  vaddr_q;
  logic             wr_q;
  logic [PA_W-1:0]  sbr_q;
  logic [VA_W-1:0]  p0_q;
  logic [VA_W-1:0]  p1_q;
  logic [PA_W-1:0]  rd_addr_q;
  logic [PA_W-1:0]  paddr_q;
  logic [1:0]       status_q;

  logic [1:0]       region;
  logic             ent_bad;
  logic [OFF_W-1:0] ent_off;
  logic [PA_W-1:0]  sys_pa_direct;
  logic [PA_W-1:0]  sys_pa_nested;

  logic             final_stage;
  logic [OFF_W-1:0] pte_off;
  logic             present;
  logic             perm_fault;
  logic [PA_W-1:0]  phys;

  seg_xlate_addr #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_addr (
    .vaddr        (vaddr_q),
    .sys_base     (sbr_q),
    .p0_base      (p0_q),
    .p1_base      (p1_q),
    .region       (region),
    .ent_bad      (ent_bad),
    .ent_off      (ent_off),
    .sys_pa_direct(sys_pa_direct),
    .sys_pa_nested(sys_pa_nested)
  );

  // The entry that yields the data address is either the user entry or a
  // system entry of a system-region access; the other case points at a user entry.
  assign final_stage = (state == S_USR_WAIT) || (region == REG_SYS);
  assign pte_off     = final_stage ? vaddr_q[OFF_W-1:0] : ent_off;

  seg_xlate_pte #(.PA_W(PA_W), .OFF_W(OFF_W)) u_pte (
    .pte       (rd_rsp_data),
    .is_write  (wr_q & final_stage),
    .offset    (pte_off),
    .present   (present),
    .perm_fault(perm_fault),
    .phys      (phys)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      vaddr_q   <= '0;
      wr_q      <= 1'b0;
      sbr_q     <= '0;
      p0_q      <= '0;
      p1_q      <= '0;
      rd_addr_q <= '0;
      paddr_q   <= '0;
      status_q  <= ST_OK;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            wr_q    <= req_write;
            sbr_q   <= sys_base;
            p0_q    <= proc0_base;
            p1_q    <= proc1_base;
            state   <= S_CLASS;
          end
        end
        S_CLASS: begin
          if (region == REG_BAD || (region != REG_SYS && ent_bad)) begin
            status_q <= ST_PROT;
            paddr_q  <= '0;
            state    <= S_DONE;
          end else begin
            rd_addr_q <= (region == REG_SYS) ? sys_pa_direct : sys_pa_nested;
            state     <= S_SYS_REQ;
          end
        end
        S_SYS_REQ: begin
          if (rd_req_ready) state <= S_SYS_WAIT;
        end
        S_SYS_WAIT: begin
          if (rd_rsp_valid) begin
            if (!present) begin
              status_q <= ST_SYS_PF;
              paddr_q  <= '0;
              state    <= S_DONE;
            end else if (region != REG_SYS) begin
              rd_addr_q <= phys;
              state     <= S_USR_REQ;
            end else if (perm_fault) begin
              status_q <= ST_PROT;
              paddr_q  <= '0;
              state    <= S_DONE;
            end else begin
              status_q <= ST_OK;
              paddr_q  <= phys;
              state    <= S_DONE;
            end
          end
        end
        S_USR_REQ: begin
          if (rd_req_ready) state <= S_USR_WAIT;
        end
        S_USR_WAIT: begin
          if (rd_rsp_valid) begin
            if (!present) begin
              status_q <= ST_USR_PF;
              paddr_q  <= '0;
            end else if (perm_fault) begin
              status_q <= ST_PROT;
              paddr_q  <= '0;
            end else begin
              status_q <= ST_OK;
              paddr_q  <= phys;
            end
            state <= S_DONE;
          end
        end
        S_DONE: begin
          if (resp_ready) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == S_IDLE);
  assign rd_req_valid = (state == S_SYS_REQ) || (state == S_USR_REQ);
  assign rd_addr      = rd_addr_q;
  assign resp_valid   = (state == S_DONE);
  assign resp_paddr   = paddr_q;
  assign resp_status  = status_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_region,
  input logic            rd_req_valid,
  input logic            rd_req_ready,
  input logic [PA_W-1:0] rd_addr,
  input logic            resp_valid,
  input logic            resp_ready,
  input logic [PA_W-1:0] resp_paddr,
  input logic [1:0]      resp_status
);

  // R1
  bad_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_region == 2'b11) |=> ##1 (resp_valid && resp_status == 2'd3));

  // R1
  bad_region_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_region == 2'b11) |=> !rd_req_valid);

  // R8
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(resp_valid || rd_req_valid));

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr) && $stable(resp_status)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  // R7
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status != 2'd0) |-> resp_paddr == '0);

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_region  (req_vaddr[VA_W-1 -: 2]),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_addr     (rd_addr),
  .resp_valid  (resp_valid),
  .resp_ready  (resp_ready),
  .resp_paddr  (resp_paddr),
  .resp_status (resp_status)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic [29:0] sys_base;
  logic [31:0] proc0_base;
  logic [31:0] proc1_base;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [29:0] rd_addr;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        resp_valid;
  logic        resp_ready;
  logic [29:0] resp_paddr;
  logic [1:0]  resp_status;

  always #2 clk = ~clk;

  seg_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .sys_base(sys_base), .proc0_base(proc0_base), .proc1_base(proc1_base),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_paddr(resp_paddr), .resp_status(resp_status)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int rd_cnt = 0;
  logic [29:0] rd_log [4];
  logic [31:0] mem [logic [29:0]];

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] lk(input logic [29:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] rand_pte();
    logic [31:0] r;
    r = $urandom;
    r[31] = ($urandom % 8) != 0;
    r[30] = ($urandom % 4) != 0;
    return r;
  endfunction

  // Reference walk built from the requirements
  function automatic void model(input logic [31:0] va, input logic wr,
                                input logic [29:0] sbr, input logic [31:0] p0, input logic [31:0] p1,
                                output logic [1:0] st, output logic [29:0] pa, output int nr,
                                output logic [29:0] a1, output logic [29:0] a2, output string lab);
    logic [31:0] ev, e1, e2;
    st = 2'd3; pa = '0; nr = 0; a1 = '0; a2 = '0; lab = "R1";
    if (va[31:30] == 2'b10) begin
      a1 = sbr + {7'b0, va[29:9], 2'b00};
      e1 = lk(a1); nr = 1;
      if (!e1[31]) begin st = 2'd1; lab = "R5"; end
      else if (wr && !e1[30]) begin st = 2'd3; lab = "R7"; end
      else begin st = 2'd0; pa = {e1[20:0], va[8:0]}; lab = "R2"; end
    end else if (va[31:30] != 2'b11) begin
      ev = (va[30] ? p1 : p0) + {9'b0, va[29:9], 2'b00};
      if (ev[31:30] != 2'b10) lab = "R3";
      else begin
        a1 = sbr + {7'b0, ev[29:9], 2'b00};
        e1 = lk(a1); nr = 1;
        if (!e1[31]) begin st = 2'd1; lab = "R5"; end
        else begin
          a2 = {e1[20:0], ev[8:0]};
          e2 = lk(a2); nr = 2;
          if (!e2[31]) begin st = 2'd2; lab = "R6"; end
          else if (wr && !e2[30]) begin st = 2'd3; lab = "R7"; end
          else begin st = 2'd0; pa = {e2[20:0], va[8:0]}; lab = "R4"; end
        end
      end
    end
  endfunction

  // Place entries along the walk of va under the current bases
  task automatic populate(input logic [31:0] va, input logic [31:0] e1, input logic [31:0] e2);
    logic [31:0] ev;
    logic [29:0] a;
    if (va[31:30] == 2'b10) begin
      mem[sys_base + {7'b0, va[29:9], 2'b00}] = e1;
    end else if (va[31:30] != 2'b11) begin
      ev = (va[30] ? proc1_base : proc0_base) + {9'b0, va[29:9], 2'b00};
      if (ev[31:30] == 2'b10) begin
        a = sys_base + {7'b0, ev[29:9], 2'b00};
        mem[a] = e1;
        mem[{e1[20:0], ev[8:0]}] = e2;
      end
    end
  endtask

  // Memory model: random grant delay, reply 1..3 cycles after grant
  initial begin
    logic [29:0] hold;
    logic [29:0] a;
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = $urandom;
      if (rd_req_valid === 1'b1) begin
        while ($urandom % 3 == 0) begin
          hold = rd_addr;
          @(negedge clk);
          // R10: request stays up with the same address while not granted
          check(rd_req_valid === 1'b1 && rd_addr === hold, "R10", {33'b0, rd_req_valid, rd_addr}, {33'b0, 1'b1, hold});
        end
        rd_req_ready = 1'b1;
        a = rd_addr;
        if (rd_cnt < 4) rd_log[rd_cnt] = a;
        rd_cnt++;
        @(negedge clk);
        rd_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = lk(a);
      end
    end
  end

  task automatic run(input logic [31:0] va, input logic wr, input bit scr);
    logic [1:0]  st;
    logic [29:0] pa, a1, a2, sv_s;
    logic [31:0] sv_0, sv_1;
    int nr, cyc, h;
    string lab;
    model(va, wr, sys_base, proc0_base, proc1_base, st, pa, nr, a1, a2, lab);
    if (scr) lab = {lab, " R11"};
    rd_cnt = 0;
    @(negedge clk);
    check(req_ready === 1'b1, "R8", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = $urandom; req_write = $urandom;
    sv_s = sys_base; sv_0 = proc0_base; sv_1 = proc1_base;
    if (scr) begin
      sys_base = $urandom; proc0_base = $urandom; proc1_base = $urandom;
    end
    check(req_ready === 1'b0, "R8", req_ready, 0);
    cyc = 1;
    while (resp_valid !== 1'b1 && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    if (nr == 0) check(cyc == 2, lab, cyc, 2);
    check(resp_valid === 1'b1, lab, resp_valid, 1);
    check(resp_status === st, lab, resp_status, st);
    check(resp_paddr === pa, lab, resp_paddr, pa);
    check(rd_cnt == nr, lab, rd_cnt, nr);
    if (nr > 0) check(rd_log[0] === a1, lab, rd_log[0], a1);
    if (nr > 1) check(rd_log[1] === a2, lab, rd_log[1], a2);
    h = $urandom % 3;
    repeat (h) begin
      @(negedge clk);
      // R9: result held while stalled
      check(resp_valid === 1'b1 && resp_status === st && resp_paddr === pa, "R9",
            {31'b0, resp_valid, resp_status, resp_paddr}, {31'b0, 1'b1, st, pa});
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    check(resp_valid === 1'b0 && req_ready === 1'b1, "R8", {resp_valid, req_ready}, 2'b01);
    sys_base = sv_s; proc0_base = sv_0; proc1_base = sv_1;
  endtask

  initial begin
    logic [31:0] va;
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; resp_ready = 1'b0;
    sys_base = 30'h0000_1000; proc0_base = 32'h8000_4000; proc1_base = 32'h8001_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle after reset
    check(req_ready === 1'b1 && rd_req_valid === 1'b0 && resp_valid === 1'b0, "R8",
          {req_ready, rd_req_valid, resp_valid}, 3'b100);

    // R1: forbidden region
    run(32'hC000_0123, 1'b0, 0);
    // R2: system hit
    va = 32'h8000_0BAB;
    populate(va, 32'hC012_3456, 32'h0);
    run(va, 1'b0, 0);
    // R5: system entry absent
    va = 32'h8000_2001;
    populate(va, 32'h4000_0077, 32'h0);
    run(va, 1'b0, 0);
    // R7: write to read-only system page, then read of it
    va = 32'h8000_4010;
    populate(va, 32'h8000_0ABC, 32'h0);
    run(va, 1'b1, 0);
    run(va, 1'b0, 0);
    // R3: entry address leaves system space
    proc0_base = 32'h0000_0000;
    run(32'h0000_1200, 1'b0, 0);
    proc0_base = 32'h8000_4000;
    // R4: nested hit through stack base
    va = 32'h4000_0E05;
    populate(va, 32'hC000_0321, 32'hC01F_FFFF);
    run(va, 1'b1, 0);
    // R5: nested, system stage absent
    va = 32'h0000_3A00;
    populate(va, 32'h0000_0010, 32'hC000_0001);
    run(va, 1'b0, 0);
    // R6: nested, user entry absent
    va = 32'h0000_5C00;
    populate(va, 32'hC000_0200, 32'h7FFF_FFFF);
    run(va, 1'b0, 0);
    // R7: nested, write to read-only user page; absent wins over permission
    va = 32'h0000_7E00;
    populate(va, 32'hC000_0300, 32'h8000_0444);
    run(va, 1'b1, 0);
    va = 32'h0000_9E00;
    populate(va, 32'hC000_0301, 32'h0000_0444);
    run(va, 1'b1, 0);
    // R2: table address wraps modulo 2^30
    sys_base = 30'h3FFF_FFF0;
    va = 32'h8000_1000;
    populate(va, 32'hC000_0055, 32'h0);
    run(va, 1'b0, 0);
    sys_base = 30'h0000_1000;
    // R11: inputs scrambled after acceptance
    va = 32'h4000_0E05;
    run(va, 1'b1, 1);

    for (int i = 0; i < 300; i++) begin
      sys_base   = $urandom;
      proc0_base = ($urandom % 6 == 0) ? $urandom : {2'b10, 30'($urandom)};
      proc1_base = ($urandom % 6 == 0) ? $urandom : {2'b10, 30'($urandom)};
      va = $urandom;
      populate(va, rand_pte(), rand_pte());
      run(va, 1'($urandom % 2), ($urandom % 4) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule